// File: doc/BRIEF.md
# Serial Command-Byte Register Port

This block is the slave end of a four-wire serial control link. A host microcontroller uses it to write and read a small bank of 8-bit configuration registers. The link has a serial clock, an active-low select, a serial data input and a serial data output. The output has a separate enable, so the pad can sit at high impedance whenever the port is not sending data.

A faster system clock runs the block. The three incoming lines pass through two-flop synchronizers, and the serial clock is edge-detected in the system domain.

Framing follows the select line. The first byte after select falls is the command, and every later byte in that select window is data. In the command byte, bit 7 set means read and bit 7 clear means write. Bits 6:0 give the starting register address, and the address steps by one after each data byte. Address 7FH is a read-only identification register that always returns 81H.

The state machine has four states:
- `ST_IDLE`: select is high.
- `ST_CMD`: collecting the command byte.
- `ST_WDATA`: collecting write data.
- `ST_RDATA`: shifting read data out.

It has these transitions:
- Any state goes to `ST_IDLE` when select is high.
- `ST_IDLE` goes to `ST_CMD` when select is low.
- `ST_CMD` goes to `ST_WDATA` on a complete command byte with bit 7 clear.
- `ST_CMD` goes to `ST_RDATA` on a complete command byte with bit 7 set.
- `ST_WDATA` and `ST_RDATA` hold until select rises.

Top module: `ctl_port`

## Requirements
- R1: After reset, and whenever the port is not in a read, `sdo_en` is 0.
- R2: Input bits are taken on rising edges of `sclk` while `sel_n` is low, most significant bit first, eight to a byte.
- R3: The first byte in a select-low window is the command: bit 7 = 1 selects read, bit 7 = 0 selects write, and bits 6:0 are the start address.
- R4: In a write, each complete data byte is stored at the current address, and the address then increments by one.
- R5: In a read, data leaves on `sdo`, most significant bit first. Each bit changes after a falling edge of `sclk`, `sdo_en` is 1 while driving, and consecutive bytes come from incrementing addresses.
- R6: Reading address 7FH returns 81H.
- R7: A read of an address that is neither below `NUM_REGS` nor 7FH returns 00H. Writes to such addresses, and to 7FH, change nothing.
- R8: Raising `sel_n` partway through a byte discards that byte. Raising it during a command byte leaves the next transaction unaffected.
- R9: Inside one select window, every byte after the command is data, even when its bit 7 is set.
- R10: While a read is shifting out, input bits are ignored, and no register changes.
- R11: After `sel_n` rises, `sdo_en` falls within one system clock of the synchronized select, which is at most four system clocks after the pin.
- R12: Correct operation does not depend on the `sclk` duty cycle, as long as each phase lasts at least three system clocks high and six low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from host |
| sel_n | input | 1 | Active-low select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Output-enable for `sdo` pad (1 = drive) |

## Verification
The hardest behaviour to reach from the ports is input traffic that has to be ignored. One case is a read that is still streaming while the host puts a valid write command and data on the input line. The other is a select that rises mid-byte. The stimulus covers the first case by driving a write pattern on `sdi` during a two-byte read burst. It covers the second by releasing select after four bits of a data byte and after four bits of a command byte. In each case, fresh reads then show that the registers kept their earlier contents.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W - 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_WDATA,
        ST_RDATA
    } ctl_state_e;
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile #(
    parameter int                NUM_REGS = 8,
    parameter int                ADDR_W   = 7,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] ID_ADDR  = '1,
    parameter logic [DATA_W-1:0] ID_VAL   = 8'h81
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(g))) begin
                regs[g] <= wr_data;
            end
        end
    end

    always_comb begin
        if (rd_addr == ID_ADDR) begin
            rd_data = ID_VAL;
        end else if (rd_addr < ADDR_W'(NUM_REGS)) begin
            rd_data = regs[rd_addr[IDX_W-1:0]];
        end else begin
            rd_data = '0;
        end
    end
endmodule

// File: rtl/ctl_port.sv
module ctl_port
    import ctl_pkg::*;
#(
    parameter int               NUM_REGS = 8,
    parameter logic [BYTE_W-1:0] ID_VAL  = 8'h81
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic sel_n,
    input  logic sdi,
    output logic sdo,
    output logic sdo_en
);
    localparam logic [ADDR_W-1:0] ID_ADDR = '1;
    localparam int                CNT_W   = $clog2(BYTE_W);

    logic              sclk_s, sel_s, sdi_s, sclk_q;
    logic              rise, fall, byte_done;
    logic [BYTE_W-1:0] sh, byte_in, rd_data;
    logic [ADDR_W-1:0] addr;
    logic [CNT_W-1:0]  bit_cnt;
    logic              wr_en, sdo_q, oe_q;
    ctl_state_e        state, nxt;

    ctl_sync #(.W(3), .RST_VAL(3'b110)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk, sel_n, sdi}),
        .q     ({sclk_s, sel_s, sdi_s})
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b1;
        else        sclk_q <= sclk_s;
    end

    assign rise      = sclk_s & ~sclk_q;
    assign fall      = ~sclk_s & sclk_q;
    assign byte_in   = {sh[BYTE_W-2:0], sdi_s};
    assign byte_done = rise && (bit_cnt == CNT_W'(BYTE_W - 1));
    assign wr_en     = (state == ST_WDATA) && byte_done && !sel_s;

    ctl_regfile #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W),
        .DATA_W   (BYTE_W),
        .ID_ADDR  (ID_ADDR),
        .ID_VAL   (ID_VAL)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (addr),
        .wr_data (byte_in),
        .rd_addr (addr),
        .rd_data (rd_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (sel_s) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  nxt = ST_CMD;
                ST_CMD:   if (byte_done) nxt = byte_in[BYTE_W-1] ? ST_RDATA : ST_WDATA;
                ST_WDATA: nxt = ST_WDATA;
                ST_RDATA: nxt = ST_RDATA;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh      <= '0;
            addr    <= '0;
            bit_cnt <= '0;
            sdo_q   <= 1'b0;
            oe_q    <= 1'b0;
        end else if (sel_s) begin
            bit_cnt <= '0;
            sdo_q   <= 1'b0;
            oe_q    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    bit_cnt <= '0;
                end
                ST_CMD: begin
                    if (rise) begin
                        sh      <= byte_in;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (byte_done) addr <= byte_in[ADDR_W-1:0];
                    end
                end
                ST_WDATA: begin
                    if (rise) begin
                        sh      <= byte_in;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (byte_done) addr <= addr + 1'b1;
                    end
                end
                ST_RDATA: begin
                    if (fall) begin
                        oe_q    <= 1'b1;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == '0) begin
                            sdo_q <= rd_data[BYTE_W-1];
                            sh    <= {rd_data[BYTE_W-2:0], 1'b0};
                            addr  <= addr + 1'b1;
                        end else begin
                            sdo_q <= sh[BYTE_W-1];
                            sh    <= {sh[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sdo    = sdo_q;
    assign sdo_en = oe_q;
endmodule

// File: rtl/ctl_port_chk.sv
module ctl_port_chk
    import ctl_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sel_s,
    input ctl_state_e state,
    input logic       fall,
    input logic       wr_en,
    input logic [6:0] rd_addr,
    input logic [7:0] rd_data,
    input logic       sdo,
    input logic       sdo_en
);
    // R11
    sel_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_s |=> !sdo_en);

    // R1
    oe_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_en |-> (state == ST_RDATA));

    // R10
    no_write_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDATA) |-> !wr_en);

    // R5
    sdo_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_en && $past(sdo_en) && !$past(fall)) |-> $stable(sdo));

    // R6
    id_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 7'h7F) |-> (rd_data == 8'h81));
endmodule

bind ctl_port ctl_port_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_s   (sel_s),
    .state   (state),
    .fall    (fall),
    .wr_en   (wr_en),
    .rd_addr (addr),
    .rd_data (rd_data),
    .sdo     (sdo),
    .sdo_en  (sdo_en)
);

// File: tb/tb_ctl_port.sv
module tb_ctl_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1;
    logic sel_n = 1'b1;
    logic sdi = 1'b0;
    logic sdo, sdo_en;

    int n_chk = 0;
    int n_bad = 0;
    int lo_cyc = 8;
    int hi_cyc = 8;

    always #4 clk = ~clk;

    ctl_port dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk   (sclk),
        .sel_n  (sel_n),
        .sdi    (sdi),
        .sdo    (sdo),
        .sdo_en (sdo_en)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic sel_lo();
        @(negedge clk);
        sel_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic sel_hi();
        @(negedge clk);
        sel_n = 1'b1;
        sclk  = 1'b1;
        repeat (4) @(negedge clk);
        check(sdo_en == 1'b0, "R11 sdo_en after release", sdo_en, 0);
        repeat (2) @(negedge clk);
    endtask

    // one byte each way; en_all reports sdo_en seen at every sample
    task automatic xfer(input logic [7:0] tx, input int nbits,
                        output logic [7:0] rx, output bit en_all);
        en_all = 1'b1;
        rx = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            sclk = 1'b0;
            sdi  = tx[i];
            repeat (lo_cyc) @(negedge clk);
            rx[i] = sdo;
            if (!sdo_en) en_all = 1'b0;
            sclk = 1'b1;
            repeat (hi_cyc) @(negedge clk);
        end
    endtask

    task automatic wr1(input logic [7:0] cmd, input logic [7:0] d);
        logic [7:0] rx;
        bit e;
        sel_lo();
        xfer(cmd, 8, rx, e);
        xfer(d, 8, rx, e);
        sel_hi();
    endtask

    task automatic rd_chk(input logic [6:0] a, input logic [7:0] exp, input string req);
        logic [7:0] rx;
        bit e;
        sel_lo();
        xfer({1'b1, a}, 8, rx, e);
        check(sdo_en == 1'b0, {req, " R1 idle before data"}, sdo_en, 0);
        xfer(8'h00, 8, rx, e);
        check(rx == exp, req, rx, exp);
        check(e, {req, " R5 sdo_en during read"}, e, 1);
        sel_hi();
    endtask

    task automatic t_reset();
        check(sdo_en == 1'b0, "R1 reset sdo_en", sdo_en, 0);
        rd_chk(7'h03, 8'h00, "R1 reset register value");
    endtask

    task automatic t_single();
        wr1(8'h03, 8'hA5);
        rd_chk(7'h03, 8'hA5, "R2 R3 R4 single write/read");
    endtask

    task automatic t_burst();
        logic [7:0] rx;
        bit e;
        sel_lo();
        xfer(8'h04, 8, rx, e);
        xfer(8'h11, 8, rx, e);
        xfer(8'hC3, 8, rx, e);
        xfer(8'h7E, 8, rx, e);
        sel_hi();
        sel_lo();
        xfer(8'h84, 8, rx, e);
        xfer(8'h00, 8, rx, e);
        check(rx == 8'h11, "R5 burst byte 0", rx, 8'h11);
        xfer(8'h00, 8, rx, e);
        check(rx == 8'hC3, "R9 data byte with bit7 set", rx, 8'hC3);
        xfer(8'h00, 8, rx, e);
        check(rx == 8'h7E, "R4 auto-increment byte 2", rx, 8'h7E);
        sel_hi();
    endtask

    task automatic t_ident();
        rd_chk(7'h7F, 8'h81, "R6 identification");
    endtask

    task automatic t_illegal();
        wr1(8'h10, 8'h55);
        rd_chk(7'h10, 8'h00, "R7 illegal address read");
        wr1(8'h7F, 8'h00);
        rd_chk(7'h7F, 8'h81, "R7 write to id ignored");
    endtask

    task automatic t_abort();
        logic [7:0] rx;
        bit e;
        wr1(8'h02, 8'h3C);
        sel_lo();
        xfer(8'h02, 8, rx, e);
        xfer(8'hFF, 4, rx, e);
        sel_hi();
        rd_chk(7'h02, 8'h3C, "R8 aborted data byte discarded");
        sel_lo();
        xfer(8'h05, 4, rx, e);
        sel_hi();
        rd_chk(7'h05, 8'hC3, "R8 aborted command harmless");
    endtask

    task automatic t_read_ignore();
        logic [7:0] rx;
        bit e;
        sel_lo();
        xfer(8'h83, 8, rx, e);
        xfer(8'h03, 8, rx, e);
        check(rx == 8'hA5, "R10 read while sdi busy byte 0", rx, 8'hA5);
        xfer(8'hFF, 8, rx, e);
        check(rx == 8'h11, "R10 read while sdi busy byte 1", rx, 8'h11);
        sel_hi();
        rd_chk(7'h03, 8'hA5, "R10 reg 3 unchanged");
        rd_chk(7'h04, 8'h11, "R10 reg 4 unchanged");
    endtask

    task automatic t_duty();
        hi_cyc = 3;
        lo_cyc = 9;
        wr1(8'h01, 8'h96);
        rd_chk(7'h01, 8'h96, "R12 short-high duty");
        hi_cyc = 12;
        lo_cyc = 6;
        wr1(8'h07, 8'h4B);
        rd_chk(7'h07, 8'h4B, "R12 short-low duty");
        hi_cyc = 8;
        lo_cyc = 8;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_single();
        t_burst();
        t_ident();
        t_illegal();
        t_abort();
        t_read_ignore();
        t_duty();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule